// File: doc/BRIEF.md
# Buffered Output-Compare PWM Channel

This block is the output stage of a timer. A free-running up-counter restarts at zero once it reaches a programmable modulo value. Each restart is an overflow, so the time between overflows is the PWM period. A compare register names a count value. When the counter equals that value, the output pin is forced to a programmed level. When toggle-on-overflow is also enabled, the pin inverts at every overflow. The pulse width is then the distance from the overflow to the compare point.

In single mode, channel 0 and channel 1 each drive their own pin from their own compare and control registers. When the link bit is set, the two compare registers form one buffered channel that drives only the channel 0 pin:

- Channel 0 controls the pin first.
- A write to the register that is not in control is held back until the next overflow.
- At each overflow, the register that was written last takes control.

This lets software load a new duty value without a glitch. An active-register flag tells software which register it must not touch.

Top module: `ocbuf_pwm`

## Requirements
- R1: During and after reset, the count, both pins and the active flag are 0, channel 1 drives its pin, and the modulo register holds all ones.
- R2: The count rises by one each cycle and returns to 0 on the cycle after it equals the modulo value (write address 2). `ovfStrobe` is high for exactly that one cycle, so the period is modulo+1 cycles.
- R3: If the count already exceeds a newly written modulo value, the overflow happens on the very next cycle and the count then restarts at 0.
- R4: In single mode, a count equal to compare 0 (address 0) loads the channel 0 pin with control bit 1 of address 3 (1 sets, 0 clears) at the next edge. Bit 0 of the same register enables inversion at overflow. This gives a high time of C+1 cycles when clearing and M-C cycles when setting, for C < M.
- R5: When a compare match and an overflow fall in the same cycle, the compare level wins over the toggle. With C = M this gives 0% duty when clearing and 100% when setting.
- R6: A compare value above the modulo value never matches. The pin then only inverts at each overflow, giving exactly M+1 high cycles over two periods.
- R7: In single mode, the channel 1 pin follows compare 1 (address 1) and control register 4 (bit 0 toggle, bit 1 level) in the same way, independently of channel 0.
- R8: Bit 2 of address 3 links the pair. While linked:
  - channel 0 is in control first;
  - `pin1Driven` is 0 and the channel 1 pin holds its value;
  - writes to address 4 have no effect.
  
  Clearing the link bit returns the flag to 0 on the next cycle.
- R9: While linked, a write to the register not in control changes nothing until the next overflow. `activeSel` switches on the cycle after the overflow cycle.
- R10: If both compare registers are written within one period, the one written later is in control after the overflow.
- R11: A write to the register in control moves the compare point from the next cycle, within the current period.
- R12: A compare write in the overflow cycle itself counts toward that overflow's hand-over.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register select: 0 compare 0, 1 compare 1, 2 modulo, 3 control 0, 4 control 1 |
| wrData | input | CNT_W | Write data |
| countOut | output | CNT_W | Current counter value |
| ovfStrobe | output | 1 | High in the cycle the counter wraps |
| matchStrobe | output | 1 | Compare match of the register steering the channel 0 pin |
| pin0Out | output | 1 | Channel 0 pin (buffered output when linked) |
| pin1Out | output | 1 | Channel 1 pin |
| pin1Driven | output | 1 | 1 while channel 1 owns its pin, 0 when released |
| activeSel | output | 1 | Compare register in control: 0 channel 0, 1 channel 1 |

## Verification
Two pairs of events can land in the same cycle.

The first pair is a compare match and an overflow. It is provoked by sweeping every compare value from 0 to one past the modulo, for every modulo value of a 4-bit counter. The case C = M must give a flat 0% or 100% output rather than a toggle.

The second pair is a compare-register write and the overflow that performs the hand-over. It is provoked by issuing the write exactly in the cycle where `ovfStrobe` is high. The result is judged from `activeSel` one cycle later and from the measured high time of the following period.

// File: rtl/ocbuf_pkg.sv
package ocbuf_pkg;
  localparam int ADDR_W  = 3;
  localparam int NUM_CH  = 2;
  localparam int CTRL0_W = 3;
  localparam int CTRL1_W = 2;

  localparam logic [ADDR_W-1:0] ADDR_CMP0  = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_CMP1  = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_MOD   = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_CTRL0 = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_CTRL1 = 3'd4;

  // control register bit positions
  localparam int BIT_TOG  = 0;
  localparam int BIT_LVL  = 1;
  localparam int BIT_LINK = 2;

  // datapath -> control
  typedef struct packed {
    logic ovf;
    logic hit0;
    logic hit1;
    logic link;
    logic tog0;
    logic lvl0;
    logic tog1;
    logic lvl1;
    logic wrCmp0;
    logic wrCmp1;
  } dpFlags_t;

  // control -> datapath pin strobes
  typedef struct packed {
    logic pin0Load;
    logic pin0Val;
    logic pin0Tgl;
    logic pin1Load;
    logic pin1Val;
    logic pin1Tgl;
  } pinStrb_t;
endpackage

// File: rtl/ocbuf_datapath.sv
module ocbuf_datapath
  import ocbuf_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [CNT_W-1:0]  wrData,
  input  pinStrb_t          strb,
  output dpFlags_t          flags,
  output logic [CNT_W-1:0]  countOut,
  output logic [CNT_W-1:0]  modOut,
  output logic              pin0Out,
  output logic              pin1Out
);

  logic [CNT_W-1:0]   cmpReg [NUM_CH];
  logic [CNT_W-1:0]   modReg;
  logic [CTRL0_W-1:0] ctrl0Reg;
  logic [CTRL1_W-1:0] ctrl1Reg;
  logic [CNT_W-1:0]   cnt;
  logic               pin0Q;
  logic               pin1Q;
  logic               wrapNow;
  logic [NUM_CH-1:0]  hit;
  logic [NUM_CH-1:0]  wrHit;

  // one compare register and comparator per channel
  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_CMP0 + ADDR_W'(g);

    assign wrHit[g] = wrEn && (wrAddr == MY_ADDR);
    assign hit[g]   = (cnt == cmpReg[g]);

    always_ff @(posedge clk) begin
      if (!rstN)         cmpReg[g] <= '0;
      else if (wrHit[g]) cmpReg[g] <= wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modReg   <= '1;
      ctrl0Reg <= '0;
      ctrl1Reg <= '0;
    end else if (wrEn) begin
      case (wrAddr)
        ADDR_MOD:   modReg   <= wrData;
        ADDR_CTRL0: ctrl0Reg <= wrData[CTRL0_W-1:0];
        ADDR_CTRL1: ctrl1Reg <= wrData[CTRL1_W-1:0];
        default: ;
      endcase
    end
  end

  // wrap also catches a count left above a shrunk modulo
  assign wrapNow = (cnt >= modReg);

  always_ff @(posedge clk) begin
    if (!rstN)        cnt <= '0;
    else if (wrapNow) cnt <= '0;
    else              cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pin0Q <= 1'b0;
      pin1Q <= 1'b0;
    end else begin
      if (strb.pin0Load)     pin0Q <= strb.pin0Val;
      else if (strb.pin0Tgl) pin0Q <= ~pin0Q;
      if (strb.pin1Load)     pin1Q <= strb.pin1Val;
      else if (strb.pin1Tgl) pin1Q <= ~pin1Q;
    end
  end

  always_comb begin
    flags.ovf    = wrapNow;
    flags.hit0   = hit[0];
    flags.hit1   = hit[1];
    flags.link   = ctrl0Reg[BIT_LINK];
    flags.tog0   = ctrl0Reg[BIT_TOG];
    flags.lvl0   = ctrl0Reg[BIT_LVL];
    flags.tog1   = ctrl1Reg[BIT_TOG];
    flags.lvl1   = ctrl1Reg[BIT_LVL];
    flags.wrCmp0 = wrHit[0];
    flags.wrCmp1 = wrHit[1];
  end

  assign countOut = cnt;
  assign modOut   = modReg;
  assign pin0Out  = pin0Q;
  assign pin1Out  = pin1Q;

endmodule

// File: rtl/ocbuf_control.sv
module ocbuf_control
  import ocbuf_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  dpFlags_t flags,
  output pinStrb_t strb,
  output logic     activeSel,
  output logic     matchSel
);

  logic lastWr;
  logic lastWrNext;
  logic activeQ;
  logic activeNext;
  logic hitSel;

  // most recent compare write while linked; a write in this cycle counts
  always_comb begin
    if (!flags.link)       lastWrNext = 1'b0;
    else if (flags.wrCmp1) lastWrNext = 1'b1;
    else if (flags.wrCmp0) lastWrNext = 1'b0;
    else                   lastWrNext = lastWr;
  end

  // hand-over happens only at overflow
  always_comb begin
    if (!flags.link)    activeNext = 1'b0;
    else if (flags.ovf) activeNext = lastWrNext;
    else                activeNext = activeQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lastWr  <= 1'b0;
      activeQ <= 1'b0;
    end else begin
      lastWr  <= lastWrNext;
      activeQ <= activeNext;
    end
  end

  assign hitSel = flags.link ? (activeQ ? flags.hit1 : flags.hit0) : flags.hit0;

  // compare level takes priority over overflow toggle
  always_comb begin
    strb.pin0Load = hitSel;
    strb.pin0Val  = flags.lvl0;
    strb.pin0Tgl  = flags.ovf && flags.tog0 && !hitSel;
    strb.pin1Load = !flags.link && flags.hit1;
    strb.pin1Val  = flags.lvl1;
    strb.pin1Tgl  = !flags.link && flags.ovf && flags.tog1 && !flags.hit1;
  end

  assign activeSel = activeQ;
  assign matchSel  = hitSel;

endmodule

// File: rtl/ocbuf_pwm.sv
module ocbuf_pwm
  import ocbuf_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [CNT_W-1:0]  wrData,
  output logic [CNT_W-1:0]  countOut,
  output logic              ovfStrobe,
  output logic              matchStrobe,
  output logic              pin0Out,
  output logic              pin1Out,
  output logic              pin1Driven,
  output logic              activeSel
);

  dpFlags_t         flags;
  pinStrb_t         strb;
  logic [CNT_W-1:0] modVal;
  logic             linkedMode;
  logic             pin0Level;

  ocbuf_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (wrEn),
    .wrAddr   (wrAddr),
    .wrData   (wrData),
    .strb     (strb),
    .flags    (flags),
    .countOut (countOut),
    .modOut   (modVal),
    .pin0Out  (pin0Out),
    .pin1Out  (pin1Out)
  );

  ocbuf_control u_ctl (
    .clk       (clk),
    .rstN      (rstN),
    .flags     (flags),
    .strb      (strb),
    .activeSel (activeSel),
    .matchSel  (matchStrobe)
  );

  assign ovfStrobe  = flags.ovf;
  assign linkedMode = flags.link;
  assign pin0Level  = flags.lvl0;
  assign pin1Driven = !flags.link;

endmodule

// File: rtl/ocbuf_pwm_checker.sv
module ocbuf_pwm_checker #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic [CNT_W-1:0] countOut,
  input logic [CNT_W-1:0] modVal,
  input logic             ovfStrobe,
  input logic             matchStrobe,
  input logic             pin0Out,
  input logic             pin1Out,
  input logic             activeSel,
  input logic             linkedMode,
  input logic             pin0Level
);

  a_r2_count_step: assert property (@(posedge clk) disable iff (!rstN)
    !ovfStrobe |=> countOut == $past(countOut) + CNT_W'(1));

  a_r2_count_wrap: assert property (@(posedge clk) disable iff (!rstN)
    ovfStrobe |=> countOut == '0);

  a_r2_ovf_single: assert property (@(posedge clk) disable iff (!rstN)
    ovfStrobe |=> (!ovfStrobe || modVal == '0));

  a_r4_match_level: assert property (@(posedge clk) disable iff (!rstN)
    matchStrobe |=> pin0Out == $past(pin0Level));

  a_r5_match_beats_toggle: assert property (@(posedge clk) disable iff (!rstN)
    (matchStrobe && ovfStrobe) |=> pin0Out == $past(pin0Level));

  a_r8_unlinked_ch0: assert property (@(posedge clk) disable iff (!rstN)
    !linkedMode |=> !activeSel);

  a_r8_pin1_hold: assert property (@(posedge clk) disable iff (!rstN)
    linkedMode |=> $stable(pin1Out));

  a_r9_switch_at_ovf: assert property (@(posedge clk) disable iff (!rstN)
    (linkedMode && !ovfStrobe) |=> (!linkedMode || $stable(activeSel)));

endmodule

bind ocbuf_pwm ocbuf_pwm_checker #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .countOut    (countOut),
  .modVal      (modVal),
  .ovfStrobe   (ovfStrobe),
  .matchStrobe (matchStrobe),
  .pin0Out     (pin0Out),
  .pin1Out     (pin1Out),
  .activeSel   (activeSel),
  .linkedMode  (linkedMode),
  .pin0Level   (pin0Level)
);

// File: tb/ocbuf_pwm_bench.sv
module ocbuf_pwm_bench;
  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rstN;
  logic         wrEn;
  logic [2:0]   wrAddr;
  logic [W-1:0] wrData;
  logic [W-1:0] countOut;
  logic         ovfStrobe, matchStrobe, pin0Out, pin1Out, pin1Driven, activeSel;

  int nTests = 0;
  int nFail  = 0;

  always #5 clk = ~clk;

  ocbuf_pwm #(.CNT_W(W)) u_ocbuf_pwm (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .countOut(countOut), .ovfStrobe(ovfStrobe), .matchStrobe(matchStrobe),
    .pin0Out(pin0Out), .pin1Out(pin1Out), .pin1Driven(pin1Driven),
    .activeSel(activeSel)
  );

  task automatic chk(input string tag, input int act, input int exp);
    nTests++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // called at a negedge; returns at the following negedge
  task automatic wr(input int a, input int d);
    wrEn = 1'b1; wrAddr = 3'(a); wrData = W'(d);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic waitOvf();
    int k = 0;
    while (!ovfStrobe && k < 100) begin
      @(negedge clk);
      k++;
    end
  endtask

  task automatic measure(input int sel, input int m, input int per, output int hi);
    hi = 0;
    waitOvf();
    for (int i = 0; i < per * (m + 1); i++) begin
      @(negedge clk);
      hi += sel ? int'(pin1Out) : int'(pin0Out);
    end
  endtask

  function automatic int expHigh(input int m, input int c, input int lv);
    if (c > m)  return m + 1;          // two periods of pure toggling
    if (c == m) return lv ? m + 1 : 0;
    return lv ? m - c : c + 1;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    int hi;
    int p1;
    int changes;
    rstN = 1'b0; wrEn = 1'b0; wrAddr = '0; wrData = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 count", countOut, 0);
    chk("R1 pin0", pin0Out, 0);
    chk("R1 pin1", pin1Out, 0);
    chk("R1 active", activeSel, 0);
    chk("R1 pin1Driven", pin1Driven, 1);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 count after release", countOut, 1);

    // R2 counter sequence and single-cycle strobe
    wr(2, 5);
    waitOvf();
    for (int i = 0; i <= 5; i++) begin
      @(negedge clk);
      chk("R2 count", countOut, i);
      chk("R2 ovf", ovfStrobe, (i == 5) ? 1 : 0);
    end

    // R4 R5 R6 sweep of every modulo/compare pair, both levels
    for (int m = 1; m <= 14; m++) begin
      for (int c = 0; c <= m + 1; c++) begin
        for (int lv = 0; lv < 2; lv++) begin
          wr(3, lv ? 3 : 1);
          wr(2, m);
          wr(0, c);
          measure(0, m, 1, hi);
          measure(0, m, (c > m) ? 2 : 1, hi);
          if (c == m)     chk("R5 duty", hi, expHigh(m, c, lv));
          else if (c > m) chk("R6 duty", hi, expHigh(m, c, lv));
          else            chk("R4 duty", hi, expHigh(m, c, lv));
        end
      end
    end

    // R8 linked start
    wr(3, 1);
    wr(2, 9);
    wr(1, 6);
    wr(0, 2);
    wr(3, 5);
    chk("R8 active", activeSel, 0);
    chk("R8 pin1Driven", pin1Driven, 0);
    measure(0, 9, 1, hi);
    measure(0, 9, 1, hi);
    chk("R8 ch0 duty", hi, 3);
    p1 = int'(pin1Out);
    changes = 0;
    wr(4, 3);
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (int'(pin1Out) != p1) changes++;
    end
    chk("R8 pin1 held", changes, 0);

    // R9 hand-over only at overflow
    waitOvf();
    @(negedge clk);
    wr(1, 6);
    chk("R9 before ovf", activeSel, 0);
    waitOvf();
    chk("R9 ovf cycle", activeSel, 0);
    @(negedge clk);
    chk("R9 after ovf", activeSel, 1);
    measure(0, 9, 1, hi);
    chk("R9 ch1 duty", hi, 7);

    // R10 last write wins
    wr(0, 4);
    wr(1, 5);
    measure(0, 9, 1, hi);
    chk("R10 ch1 duty", hi, 6);
    chk("R10 active", activeSel, 1);
    wr(1, 3);
    wr(0, 4);
    measure(0, 9, 1, hi);
    chk("R10 ch0 duty", hi, 5);
    chk("R10 active back", activeSel, 0);

    // R11 write to active register acts at once
    waitOvf();
    hi = 0;
    for (int i = 0; i <= 9; i++) begin
      @(negedge clk);
      hi += int'(pin0Out);
      if (i == 0) begin
        wrEn = 1'b1; wrAddr = 3'd0; wrData = W'(8);
      end else begin
        wrEn = 1'b0;
      end
    end
    chk("R11 duty", hi, 9);
    chk("R11 active", activeSel, 0);

    // R12 write in overflow cycle
    waitOvf();
    wrEn = 1'b1; wrAddr = 3'd1; wrData = W'(2);
    @(negedge clk);
    wrEn = 1'b0;
    chk("R12 active", activeSel, 1);
    measure(0, 9, 1, hi);
    chk("R12 duty", hi, 3);

    // R8 unlink
    wr(3, 1);
    @(negedge clk);
    chk("R8 unlink active", activeSel, 0);
    chk("R8 unlink pin1Driven", pin1Driven, 1);

    // R7 independent channel 1
    wr(4, 3);
    wr(1, 2);
    wr(0, 5);
    measure(1, 9, 1, hi);
    measure(1, 9, 1, hi);
    chk("R7 pin1 duty", hi, 7);
    measure(0, 9, 1, hi);
    chk("R7 pin0 duty", hi, 6);

    // R3 shrink modulo below count
    wr(2, 15);
    for (int k = 0; k < 40 && countOut != 10; k++) @(negedge clk);
    wr(2, 3);
    chk("R3 ovf", ovfStrobe, 1);
    @(negedge clk);
    chk("R3 restart", countOut, 0);

    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule